// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of zero-address instructions against an internal operand stack and a small internal data memory. Arithmetic instructions name no address: they take both operands off the stack and leave their single result there. The only instructions that touch memory are a push, which copies an addressed memory word onto the stack, and a pop, which removes the top of the stack and stores it at an address.

The unit accepts one instruction at a time through a valid/ready pair. Every instruction takes the same fixed two cycles. The accepting edge latches the opcode and address. The following edge applies the effect. The unit reports the current stack depth and the value on top of the stack, and it raises an underflow or an overflow flag for an instruction that cannot run. An instruction that cannot run leaves the stack and the memory untouched.

The data memory comes out of reset holding a computed pattern, and pops can overwrite it. A whole expression can therefore be evaluated with pushes, arithmetic and a final pop. The result can then be read back by pushing the same address and reading the top-of-stack output.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset the depth is 0, the top-of-stack output is 0, both flags are low, ready is high, and memory word i holds INIT_BASE + i*INIT_STEP, truncated to DATA_W bits.
- R2: An instruction is accepted on a clock edge where instValid and instReady are both high. Ready is low for exactly the next cycle, and the effect of the instruction is visible after the second edge.
- R3: Opcode 1 (push) with an address and a stack that is not full places memory[address] on top and raises the depth by one.
- R4: Opcode 2 (pop) with an address and a non-empty stack writes the top value to memory[address] and lowers the depth by one.
- R5: Opcodes 3 (add), 4 (subtract) and 5 (multiply), with at least two entries, remove two values, push one result and lower the depth by one. Add returns their sum modulo 2^DATA_W.
- R6: Subtract returns the old top value minus the value directly beneath it, modulo 2^DATA_W.
- R7: Multiply returns the low DATA_W bits of the product.
- R8: An arithmetic opcode with fewer than two entries, or a pop with an empty stack, raises underflowErr. The stack, the depth and the memory stay unchanged.
- R9: A push to a full stack (depth equal to STACK_DEPTH) raises overflowErr and leaves the stack and the depth unchanged.
- R10: Both flags describe only the most recently executed instruction. An instruction that runs clears them, and they are never high together.
- R11: Opcodes 0, 6 and 7 complete in the same two cycles with no effect on the stack, the depth, the memory or the flags (both flags read low afterwards).
- R12: The sequence push E, push C, push D, multiply, push B, add, subtract, push F, add, push A, add, pop A leaves B+C*D-E+F+A in memory word A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction offered this cycle |
| instOp | input | 3 | Opcode: 0 none, 1 push, 2 pop, 3 add, 4 subtract, 5 multiply, 6/7 none |
| instAddr | input | $clog2(MEM_WORDS) | Memory address for push and pop |
| instReady | output | 1 | Unit can accept an instruction |
| stackDepth | output | $clog2(STACK_DEPTH+1) | Number of entries on the stack |
| topWord | output | DATA_W | Value on top of the stack, 0 when empty |
| underflowErr | output | 1 | Last instruction lacked operands |
| overflowErr | output | 1 | Last instruction pushed to a full stack |

## Verification
The bench builds the unit with STACK_DEPTH of 4, MEM_WORDS of 8 and DATA_W of 32. The shallow stack lets biased random pushes reach the full condition often, so overflow, underflow and recovery from both occur many times in one run. The small memory makes pops and later pushes hit the same words, so values written back are read again and checked. The 32-bit width with a large odd INIT_STEP makes products and differences wrap, which exercises the truncation and the operand order of subtraction.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;

  typedef enum logic [2:0] {
    OP_NONE0 = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_MUL   = 3'd5,
    OP_NONE6 = 3'd6,
    OP_NONE7 = 3'd7
  } opCode_t;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } aluSel_t;

  // Strobes from control to datapath, valid in the execute cycle only
  typedef struct packed {
    logic    fire;       // an instruction completes at this edge
    logic    loadMem;    // push memory word onto the stack
    logic    storeMem;   // pop the top into memory
    logic    combine;    // two-operand arithmetic
    aluSel_t aluSel;
    logic    flagUnder;
    logic    flagOver;
  } dpStrobe_t;

endpackage

// File: rtl/stack_exec_ctrl.sv
module stack_exec_ctrl
  import stack_exec_pkg::*;
#(
  parameter int STACK_DEPTH = 16,
  parameter int PTR_W       = 5,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [PTR_W-1:0]  depth,
  output logic              instReady,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] addrQ
);

  typedef enum logic {S_IDLE, S_EXEC} ctrlState_t;

  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(STACK_DEPTH);
  localparam logic [PTR_W-1:0] TWO_LVL  = PTR_W'(2);

  ctrlState_t state;
  opCode_t    opQ;

  assign instReady = (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_NONE0;
      addrQ <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (instValid) begin
            opQ   <= opCode_t'(instOp);
            addrQ <= instAddr;
            state <= S_EXEC;
          end
        end
        S_EXEC: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (state == S_EXEC) begin
      strobe.fire = 1'b1;
      unique case (opQ)
        OP_PUSH: begin
          if (depth == FULL_LVL) strobe.flagOver = 1'b1;
          else                   strobe.loadMem  = 1'b1;
        end
        OP_POP: begin
          if (depth == '0) strobe.flagUnder = 1'b1;
          else             strobe.storeMem  = 1'b1;
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (depth < TWO_LVL) strobe.flagUnder = 1'b1;
          else                 strobe.combine   = 1'b1;
          strobe.aluSel = (opQ == OP_ADD) ? ALU_ADD :
                          (opQ == OP_SUB) ? ALU_SUB : ALU_MUL;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_exec_alu.sv
module stack_exec_alu
  import stack_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluSel_t           aluSel,
  input  logic [DATA_W-1:0] firstPop,
  input  logic [DATA_W-1:0] secondPop,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (aluSel)
      ALU_ADD: result = firstPop + secondPop;
      ALU_SUB: result = firstPop - secondPop;
      ALU_MUL: result = firstPop * secondPop;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/stack_exec_dp.sv
module stack_exec_dp
  import stack_exec_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              STACK_DEPTH = 16,
  parameter int              MEM_WORDS   = 16,
  parameter int              PTR_W       = 5,
  parameter int              ADDR_W      = 4,
  parameter logic [DATA_W-1:0] INIT_BASE = '0,
  parameter logic [DATA_W-1:0] INIT_STEP = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [PTR_W-1:0]  depth,
  output logic [DATA_W-1:0] topWord,
  output logic              underflowErr,
  output logic              overflowErr
);

  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [DATA_W-1:0] stackArr [STACK_DEPTH];
  logic [DATA_W-1:0] memArr   [MEM_WORDS];
  logic [IDX_W-1:0]  wrIdx, topIdx, nxtIdx;
  logic [DATA_W-1:0] topVal, nxtVal, memRd, aluOut;

  assign wrIdx  = depth[IDX_W-1:0];
  assign topIdx = IDX_W'(depth - PTR_W'(1));
  assign nxtIdx = IDX_W'(depth - PTR_W'(2));
  assign topVal = stackArr[topIdx];
  assign nxtVal = stackArr[nxtIdx];
  assign memRd  = memArr[addr];

  assign topWord = (depth == '0) ? '0 : topVal;

  stack_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .aluSel   (strobe.aluSel),
    .firstPop (topVal),
    .secondPop(nxtVal),
    .result   (aluOut)
  );

  // One register per stack slot with its own write enable
  for (genvar g = 0; g < STACK_DEPTH; g++) begin : gStack
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stackArr[g] <= '0;
      else if (strobe.loadMem && (wrIdx == IDX_W'(g)))
        stackArr[g] <= memRd;
      else if (strobe.combine && (nxtIdx == IDX_W'(g)))
        stackArr[g] <= aluOut;
    end
  end

  // Data memory words, each reset to its computed pattern
  for (genvar g = 0; g < MEM_WORDS; g++) begin : gMem
    localparam logic [DATA_W-1:0] INIT_G = INIT_BASE + DATA_W'(g) * INIT_STEP;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        memArr[g] <= INIT_G;
      else if (strobe.storeMem && (addr == ADDR_W'(g)))
        memArr[g] <= topVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth        <= '0;
      underflowErr <= 1'b0;
      overflowErr  <= 1'b0;
    end else if (strobe.fire) begin
      underflowErr <= strobe.flagUnder;
      overflowErr  <= strobe.flagOver;
      if (strobe.loadMem)
        depth <= depth + PTR_W'(1);
      else if (strobe.storeMem || strobe.combine)
        depth <= depth - PTR_W'(1);
    end
  end

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_exec_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                STACK_DEPTH = 16,
  parameter int                MEM_WORDS   = 16,
  parameter logic [DATA_W-1:0] INIT_BASE   = DATA_W'(32'h0000_0011),
  parameter logic [DATA_W-1:0] INIT_STEP   = DATA_W'(32'h9E37_79B9),
  localparam int               ADDR_W      = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1,
  localparam int               PTR_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instOp,
  input  logic [ADDR_W-1:0] instAddr,
  output logic              instReady,
  output logic [PTR_W-1:0]  stackDepth,
  output logic [DATA_W-1:0] topWord,
  output logic              underflowErr,
  output logic              overflowErr
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] addrQ;

  stack_exec_ctrl #(
    .STACK_DEPTH(STACK_DEPTH),
    .PTR_W      (PTR_W),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instOp   (instOp),
    .instAddr (instAddr),
    .depth    (stackDepth),
    .instReady(instReady),
    .strobe   (strobe),
    .addrQ    (addrQ)
  );

  stack_exec_dp #(
    .DATA_W     (DATA_W),
    .STACK_DEPTH(STACK_DEPTH),
    .MEM_WORDS  (MEM_WORDS),
    .PTR_W      (PTR_W),
    .ADDR_W     (ADDR_W),
    .INIT_BASE  (INIT_BASE),
    .INIT_STEP  (INIT_STEP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addr        (addrQ),
    .depth       (stackDepth),
    .topWord     (topWord),
    .underflowErr(underflowErr),
    .overflowErr (overflowErr)
  );

endmodule

// File: rtl/stack_exec_unit_chk.sv
module stack_exec_unit_chk #(
  parameter int DATA_W      = 32,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 4,
  parameter int PTR_W       = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              instValid,
  input logic [2:0]        instOp,
  input logic [ADDR_W-1:0] instAddr,
  input logic              instReady,
  input logic [PTR_W-1:0]  stackDepth,
  input logic [DATA_W-1:0] topWord,
  input logic              underflowErr,
  input logic              overflowErr
);

  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(STACK_DEPTH);
  localparam logic [PTR_W-1:0] TWO_LVL  = PTR_W'(2);

  logic accept, isArith, isReserved;
  assign accept     = instValid && instReady;
  assign isArith    = (instOp == 3'd3) || (instOp == 3'd4) || (instOp == 3'd5);
  assign isReserved = (instOp == 3'd0) || (instOp == 3'd6) || (instOp == 3'd7);

  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= FULL_LVL);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !instReady);

  a_r2_single_busy_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !instReady |=> instReady);

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (accept && instOp == 3'd1 && stackDepth != FULL_LVL)
      |=> ##1 (stackDepth == $past(stackDepth, 2) + PTR_W'(1)));

  a_r5_arith_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isArith && stackDepth >= TWO_LVL)
      |=> ##1 (stackDepth + PTR_W'(1) == $past(stackDepth, 2) && !underflowErr));

  a_r8_underflow_holds: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isArith && stackDepth < TWO_LVL)
      |=> ##1 (underflowErr && stackDepth == $past(stackDepth, 2)));

  a_r9_overflow_holds: assert property (@(posedge clk) disable iff (!rstN)
    (accept && instOp == 3'd1 && stackDepth == FULL_LVL)
      |=> ##1 (overflowErr && stackDepth == $past(stackDepth, 2)
               && topWord == $past(topWord, 2)));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(underflowErr && overflowErr));

  a_r11_reserved_inert: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isReserved)
      |=> ##1 (!underflowErr && !overflowErr && stackDepth == $past(stackDepth, 2)
               && topWord == $past(topWord, 2)));

  logic unusedAddr;
  assign unusedAddr = ^instAddr;

endmodule

bind stack_exec_unit stack_exec_unit_chk #(
  .DATA_W     (DATA_W),
  .STACK_DEPTH(STACK_DEPTH),
  .ADDR_W     (ADDR_W),
  .PTR_W      (PTR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .instValid   (instValid),
  .instOp      (instOp),
  .instAddr    (instAddr),
  .instReady   (instReady),
  .stackDepth  (stackDepth),
  .topWord     (topWord),
  .underflowErr(underflowErr),
  .overflowErr (overflowErr)
);

// File: tb/stack_exec_unit_bench.sv
module stack_exec_unit_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int DATA_W      = 32;
  localparam int STACK_DEPTH = 4;
  localparam int MEM_WORDS   = 8;
  localparam int ADDR_W      = $clog2(MEM_WORDS);
  localparam int PTR_W       = $clog2(STACK_DEPTH + 1);
  localparam logic [31:0] INIT_BASE = 32'h0000_0011;
  localparam logic [31:0] INIT_STEP = 32'h9E37_79B9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              instValid = 1'b0;
  logic [2:0]        instOp = '0;
  logic [ADDR_W-1:0] instAddr = '0;
  logic              instReady;
  logic [PTR_W-1:0]  stackDepth;
  logic [DATA_W-1:0] topWord;
  logic              underflowErr, overflowErr;

  stack_exec_unit #(
    .DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH), .MEM_WORDS(MEM_WORDS),
    .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
  ) u_stack_exec_unit (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instAddr(instAddr), .instReady(instReady), .stackDepth(stackDepth),
    .topWord(topWord), .underflowErr(underflowErr), .overflowErr(overflowErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic [31:0] mMem [MEM_WORDS];
  logic [31:0] mStack [STACK_DEPTH];
  int          mDepth;
  bit          mUnder, mOver;

  function automatic logic [31:0] initWord(int i);
    return INIT_BASE + 32'(i) * INIT_STEP;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelTop();
    return (mDepth == 0) ? 32'h0 : mStack[mDepth-1];
  endfunction

  // Reference behaviour from the requirements
  task automatic modelStep(input logic [2:0] op, input int addr, output string req);
    logic [31:0] a, b, r;
    mUnder = 0; mOver = 0; req = "R11";
    case (op)
      3'd1: begin
        if (mDepth == STACK_DEPTH) begin mOver = 1; req = "R9"; end
        else begin mStack[mDepth] = mMem[addr]; mDepth++; req = "R3"; end
      end
      3'd2: begin
        if (mDepth == 0) begin mUnder = 1; req = "R8"; end
        else begin mMem[addr] = mStack[mDepth-1]; mDepth--; req = "R4"; end
      end
      3'd3, 3'd4, 3'd5: begin
        if (mDepth < 2) begin mUnder = 1; req = "R8"; end
        else begin
          a = mStack[mDepth-1]; b = mStack[mDepth-2];
          if (op == 3'd3) begin r = a + b; req = "R5"; end
          else if (op == 3'd4) begin r = a - b; req = "R6"; end
          else begin r = a * b; req = "R7"; end
          mStack[mDepth-2] = r; mDepth--;
        end
      end
      default: req = "R11";
    endcase
  endtask

  task automatic doInst(input logic [2:0] op, input int addr);
    string req;
    @(negedge clk);
    instValid = 1'b1; instOp = op; instAddr = ADDR_W'(addr);
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    check(instReady == 1'b0, "R2 ready low after accept", 32'(instReady), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(instReady == 1'b1, "R2 ready back", 32'(instReady), 32'd1);
    modelStep(op, addr, req);
    check(32'(stackDepth) == 32'(mDepth), {req, " depth"}, 32'(stackDepth), 32'(mDepth));
    check(topWord == modelTop(), {req, " top"}, topWord, modelTop());
    check(underflowErr == mUnder, {req, " underflow flag"}, 32'(underflowErr), 32'(mUnder));
    check(overflowErr == mOver, {req, " overflow flag"}, 32'(overflowErr), 32'(mOver));
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] expr;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEM_WORDS; i++) mMem[i] = initWord(i);
    for (int i = 0; i < STACK_DEPTH; i++) mStack[i] = '0;
    mDepth = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(stackDepth == '0, "R1 depth", 32'(stackDepth), 32'd0);
    check(topWord == '0, "R1 top", topWord, 32'd0);
    check(!underflowErr && !overflowErr, "R1 flags", {30'd0, underflowErr, overflowErr}, 32'd0);
    check(instReady == 1'b1, "R1 ready", 32'(instReady), 32'd1);

    // R12 expression with A=0 B=1 C=2 D=3 E=4 F=5
    expr = initWord(1) + initWord(2) * initWord(3) - initWord(4) + initWord(5) + initWord(0);
    doInst(3'd1, 4); doInst(3'd1, 2); doInst(3'd1, 3); doInst(3'd5, 0);
    doInst(3'd1, 1); doInst(3'd3, 0); doInst(3'd4, 0); doInst(3'd1, 5);
    doInst(3'd3, 0); doInst(3'd1, 0); doInst(3'd3, 0); doInst(3'd2, 0);
    doInst(3'd1, 0);
    check(topWord == expr, "R12 expression result", topWord, expr);
    doInst(3'd2, 0);

    // R1 untouched memory words hold the computed pattern
    doInst(3'd1, 7);
    check(topWord == initWord(7), "R1 memory pattern", topWord, initWord(7));
    doInst(3'd2, 7);

    // R8 underflow on empty and single-entry stacks
    doInst(3'd3, 0);
    check(underflowErr == 1'b1, "R8 add on empty", 32'(underflowErr), 32'd1);
    doInst(3'd2, 6);
    check(underflowErr == 1'b1, "R8 pop on empty", 32'(underflowErr), 32'd1);
    doInst(3'd1, 6);
    check(topWord == initWord(6), "R8 memory unchanged by failed pop", topWord, initWord(6));
    doInst(3'd4, 0);
    check(stackDepth == PTR_W'(1), "R8 single entry kept", 32'(stackDepth), 32'd1);

    // R11 reserved opcodes
    doInst(3'd0, 1); doInst(3'd6, 2); doInst(3'd7, 3);
    check(topWord == initWord(6), "R11 top kept", topWord, initWord(6));

    // R9 overflow then R10 flag clear
    doInst(3'd1, 1); doInst(3'd1, 2); doInst(3'd1, 3); doInst(3'd1, 4);
    check(overflowErr == 1'b1, "R9 push on full", 32'(overflowErr), 32'd1);
    doInst(3'd6, 0);
    check(overflowErr == 1'b0, "R10 flag cleared by next instruction", 32'(overflowErr), 32'd0);
    doInst(3'd1, 4);
    doInst(3'd2, 5);
    check(!overflowErr && !underflowErr, "R10 flags low after pop", {30'd0, underflowErr, overflowErr}, 32'd0);

    // Constrained random mix, pushes favoured so the stack fills
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [2:0] op;
      sel = int'($urandom % 10);
      if (sel < 4)       op = 3'd1;
      else if (sel < 6)  op = 3'd2;
      else if (sel == 6) op = 3'd3;
      else if (sel == 7) op = 3'd4;
      else if (sel == 8) op = 3'd5;
      else begin
        int k;
        k = int'($urandom % 3);
        op = (k == 0) ? 3'd0 : (k == 1) ? 3'd6 : 3'd7;
      end
      doInst(op, int'($urandom % MEM_WORDS));
    end

    finishRun();
  end

endmodule